// File: doc/BRIEF.md
# Synchronous Transfer Negotiation Controller

This block is the host-side engine that settles the data transfer rate with a target through a message exchange. A negotiation starts with `start_i`. The block then streams a five-byte synchronous transfer request on a byte-wide outgoing message port. The period field of this request is taken from a parameterised ladder of candidate periods, sorted from fastest to slowest. The requested offset is captured from `req_offset_i` when the negotiation starts.

The block then gathers the target's reply from a byte-wide incoming message port, which marks its final byte with a last flag, and decides what to do with it:

- **Single-byte reject:** the block resends the request with the next slower rung of the ladder.
- **Reject after the slowest rung:** the block falls back to asynchronous transfer.
- **Five-byte synchronous request from the target:** this covers both plain acceptance and a counter-proposal. The block adopts the target's period. If that period is faster than the current rung, the block raises it to the rung. The block also adopts the target's offset, and an offset of zero means asynchronous transfer.
- **Any other reply:** the block ends in asynchronous mode.

The outcome is reported with a one-cycle done pulse. The mode, period and offset are held until the next negotiation completes.

Top module: `sync_neg_ctrl`

## Requirements
- R1: After reset, `done_o`, `sync_mode_o` and `mo_valid_o` are 0, and `period_o` and `offset_o` are 0.
- R2: A request is sent as bytes 0x01, 0x03, 0x01, period, offset, in that order, with `mo_valid_o` high. A byte advances only in a cycle where `mo_ready_i` is high. While `mo_ready_i` is low, `mo_valid_o` and `mo_data_o` hold.
- R3: The first request of a negotiation carries ladder entry 0 (default 0x19) as its period and the `req_offset_i` value captured at start as its offset.
- R4: A reply consisting of the single byte 0x07 marked last, received while a slower rung remains, causes the request to be resent with the next ladder entry. Default ladder: 0x19, 0x25, 0x32, 0x35, 0x3E.
- R5: A 0x07 reject of the last ladder entry ends the negotiation in asynchronous mode, with `sync_mode_o`=0 and period and offset 0.
- R6: A reply of exactly five bytes 0x01, 0x03, 0x01, P, O with O nonzero and P not below the current rung ends with `sync_mode_o`=1, `period_o`=P and `offset_o`=O.
- R7: In such a reply, a P below the current rung is raised to the current rung.
- R8: In such a reply, O equal to 0 forces asynchronous mode, with period and offset 0.
- R9: Any other reply ends in asynchronous mode. This covers wrong byte values, a wrong code, and a length other than 1 or 5.
- R10: `done_o` is high for exactly one cycle, in the cycle after the reply's last byte is accepted. The results then hold until the next completion.
- R11: `start_i` during a negotiation has no effect, and incoming bytes while idle have no effect.
- R12: `sync_mode_o`=1 always comes with a nonzero `offset_o`. `sync_mode_o`=0 always comes with zero period and offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a negotiation (used when idle) |
| req_offset_i | input | 8 | Offset to request, captured at start |
| mo_data_o | output | 8 | Outgoing message byte |
| mo_valid_o | output | 1 | Outgoing byte valid |
| mo_ready_i | input | 1 | Outgoing byte accepted |
| mi_data_i | input | 8 | Incoming message byte |
| mi_valid_i | input | 1 | Incoming byte valid |
| mi_last_i | input | 1 | Incoming byte is the last of its message |
| done_o | output | 1 | One-cycle completion pulse |
| sync_mode_o | output | 1 | 1 for synchronous, 0 for asynchronous result |
| period_o | output | 8 | Agreed period value |
| offset_o | output | 8 | Agreed offset |

## Verification
The clamp of a fast counter-proposal and the zero-offset fallback are both settled in the single cycle that consumes the reply's last byte. A reply that has a period below the current rung and also an offset of zero therefore exercises both at once. The bench sweeps proposals of one below, equal to and above every rung, each with zero and nonzero offset, so this collision is provoked at each rung. The zero offset must win: the result is asynchronous with zero period, not a clamped rung. A second collision is a reject on the last rung, where ladder exhaustion and completion fall in the same cycle. The bench checks that no further request appears and that the done pulse carries the asynchronous result.

// File: rtl/sync_neg_pkg.sv
package sync_neg_pkg;
  localparam logic [7:0] MSG_EXT     = 8'h01;
  localparam logic [7:0] SDTR_LEN    = 8'h03;
  localparam logic [7:0] SDTR_CODE   = 8'h01;
  localparam logic [7:0] MSG_REJECT  = 8'h07;
  localparam int unsigned REQ_BYTES  = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT} neg_state_e;
  typedef enum logic [1:0] {RPL_REJECT, RPL_SDTR, RPL_OTHER} reply_kind_e;
endpackage

// File: rtl/sync_neg_ladder.sv
module sync_neg_ladder #(
  parameter int unsigned N_RUNG = 5,
  parameter logic [N_RUNG*8-1:0] LADDER = {8'h3E, 8'h35, 8'h32, 8'h25, 8'h19},
  parameter int unsigned IW = $clog2(N_RUNG)
) (
  input  logic [IW-1:0] idx_i,
  output logic [7:0]    period_o,
  output logic          last_o
);
  logic [7:0] rung [N_RUNG];

  for (genvar g = 0; g < N_RUNG; g++) begin : g_rung
    assign rung[g] = LADDER[g*8 +: 8];
  end

  always_comb begin
    period_o = rung[N_RUNG-1];
    for (int i = 0; i < N_RUNG; i++) begin
      if (idx_i == IW'(i)) period_o = rung[i];
    end
  end

  assign last_o = (idx_i == IW'(N_RUNG-1));
endmodule

// File: rtl/sync_neg_reply.sv
module sync_neg_reply
  import sync_neg_pkg::*;
(
  input  logic [REQ_BYTES*8-1:0] bytes_i,
  input  logic [2:0]             count_i,
  output reply_kind_e            kind_o,
  output logic [7:0]             period_o,
  output logic [7:0]             offset_o
);
  logic [7:0] b0, b1, b2;
  assign b0       = bytes_i[7:0];
  assign b1       = bytes_i[15:8];
  assign b2       = bytes_i[23:16];
  assign period_o = bytes_i[31:24];
  assign offset_o = bytes_i[39:32];

  always_comb begin
    if (count_i == 3'd1 && b0 == MSG_REJECT)
      kind_o = RPL_REJECT;
    else if (count_i == 3'(REQ_BYTES) && b0 == MSG_EXT && b1 == SDTR_LEN && b2 == SDTR_CODE)
      kind_o = RPL_SDTR;
    else
      kind_o = RPL_OTHER;
  end
endmodule

// File: rtl/sync_neg_ctrl.sv
module sync_neg_ctrl
  import sync_neg_pkg::*;
#(
  parameter int unsigned N_RUNG = 5,
  parameter logic [N_RUNG*8-1:0] LADDER = {8'h3E, 8'h35, 8'h32, 8'h25, 8'h19}
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] req_offset_i,
  output logic [7:0] mo_data_o,
  output logic       mo_valid_o,
  input  logic       mo_ready_i,
  input  logic [7:0] mi_data_i,
  input  logic       mi_valid_i,
  input  logic       mi_last_i,
  output logic       done_o,
  output logic       sync_mode_o,
  output logic [7:0] period_o,
  output logic [7:0] offset_o
);
  localparam int unsigned IW = $clog2(N_RUNG);

  neg_state_e             state_q;
  logic [IW-1:0]          idx_q;
  logic [2:0]             tx_cnt_q;
  logic [7:0]             off_req_q;
  logic [REQ_BYTES*8-1:0] rx_q, rx_view;
  logic [2:0]             rx_cnt_q, n_view;
  logic                   done_q, sync_q;
  logic [7:0]             per_q, offs_q;

  logic [7:0]  cand;
  logic        last_rung;
  reply_kind_e kind;
  logic [7:0]  prop_per, prop_off;
  logic        fin_go, fin_sync;
  logic [7:0]  fin_per, fin_off;

  sync_neg_ladder #(.N_RUNG(N_RUNG), .LADDER(LADDER), .IW(IW)) ladder_i (
    .idx_i    (idx_q),
    .period_o (cand),
    .last_o   (last_rung)
  );

  // the byte arriving now is merged into the buffered view
  always_comb begin
    rx_view = rx_q;
    if (rx_cnt_q < 3'(REQ_BYTES)) rx_view[rx_cnt_q*8 +: 8] = mi_data_i;
    n_view = (rx_cnt_q >= 3'(REQ_BYTES)) ? 3'(REQ_BYTES + 1) : rx_cnt_q + 3'd1;
  end

  sync_neg_reply reply_i (
    .bytes_i  (rx_view),
    .count_i  (n_view),
    .kind_o   (kind),
    .period_o (prop_per),
    .offset_o (prop_off)
  );

  always_comb begin
    fin_go   = (state_q == ST_WAIT) && mi_valid_i && mi_last_i &&
               !(kind == RPL_REJECT && !last_rung);
    fin_sync = (kind == RPL_SDTR) && (prop_off != 8'd0);
    fin_per  = 8'd0;
    fin_off  = 8'd0;
    if (fin_sync) begin
      fin_per = (prop_per < cand) ? cand : prop_per;
      fin_off = prop_off;
    end
  end

  always_comb begin
    unique case (tx_cnt_q)
      3'd0:    mo_data_o = MSG_EXT;
      3'd1:    mo_data_o = SDTR_LEN;
      3'd2:    mo_data_o = SDTR_CODE;
      3'd3:    mo_data_o = cand;
      3'd4:    mo_data_o = off_req_q;
      default: mo_data_o = 8'd0;
    endcase
  end

  assign mo_valid_o = (state_q == ST_SEND);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      tx_cnt_q  <= '0;
      off_req_q <= '0;
      rx_q      <= '0;
      rx_cnt_q  <= '0;
      done_q    <= 1'b0;
      sync_q    <= 1'b0;
      per_q     <= '0;
      offs_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q   <= ST_SEND;
          idx_q     <= '0;
          tx_cnt_q  <= '0;
          off_req_q <= req_offset_i;
        end
        ST_SEND: if (mo_ready_i) begin
          if (tx_cnt_q == 3'(REQ_BYTES - 1)) begin
            state_q  <= ST_WAIT;
            rx_cnt_q <= '0;
          end else begin
            tx_cnt_q <= tx_cnt_q + 3'd1;
          end
        end
        ST_WAIT: if (mi_valid_i) begin
          if (!mi_last_i) begin
            rx_q     <= rx_view;
            rx_cnt_q <= n_view;
          end else if (fin_go) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            sync_q  <= fin_sync;
            per_q   <= fin_per;
            offs_q  <= fin_off;
          end else begin
            // rejected with a slower rung left: step down and resend
            idx_q    <= idx_q + IW'(1);
            tx_cnt_q <= '0;
            state_q  <= ST_SEND;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o      = done_q;
  assign sync_mode_o = sync_q;
  assign period_o    = per_q;
  assign offset_o    = offs_q;
endmodule

// File: rtl/sync_neg_ctrl_chk.sv
module sync_neg_ctrl_chk #(
  parameter int unsigned N_RUNG = 5,
  parameter logic [N_RUNG*8-1:0] LADDER = {8'h3E, 8'h35, 8'h32, 8'h25, 8'h19}
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] mo_data_o,
  input logic       mo_valid_o,
  input logic       mo_ready_i,
  input logic       done_o,
  input logic       sync_mode_o,
  input logic [7:0] period_o,
  input logic [7:0] offset_o
);
  a_r2_hold_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mo_valid_o && !mo_ready_i |=> mo_valid_o && $stable(mo_data_o));

  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_done_not_sending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mo_valid_o);

  a_r12_sync_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_mode_o |-> offset_o != 8'd0);

  a_r12_async_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_mode_o |-> (period_o == 8'd0 && offset_o == 8'd0));

  a_r7_period_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_mode_o |-> period_o >= LADDER[7:0]);

  a_r10_results_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(period_o) && $stable(offset_o) && $stable(sync_mode_o));
endmodule

bind sync_neg_ctrl sync_neg_ctrl_chk #(.N_RUNG(N_RUNG), .LADDER(LADDER)) chk_i (.*);

// File: tb/sync_neg_ctrl_tb_top.sv
module sync_neg_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] req_offset_i = 8'd0;
  logic [7:0] mo_data_o;
  logic       mo_valid_o;
  logic       mo_ready_i = 1'b0;
  logic [7:0] mi_data_i = 8'd0;
  logic       mi_valid_i = 1'b0;
  logic       mi_last_i = 1'b0;
  logic       done_o, sync_mode_o;
  logic [7:0] period_o, offset_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5ns clk_i = ~clk_i;

  sync_neg_ctrl dut_i (.*);

  function automatic logic [7:0] rung(input int i);
    case (i)
      0: return 8'h19;
      1: return 8'h25;
      2: return 8'h32;
      3: return 8'h35;
      default: return 8'h3E;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic get_byte(input logic [7:0] exp, input bit stall, input string req);
    logic [7:0] held;
    int guard = 0;
    while (!mo_valid_o && guard < 50) begin
      @(negedge clk_i);
      guard++;
    end
    chk(mo_valid_o, "R2 valid", int'(mo_valid_o), 1);
    if (stall) begin
      mo_ready_i = 1'b0;
      held = mo_data_o;
      @(negedge clk_i);
      chk(mo_valid_o && mo_data_o == held, "R2 stall hold", int'(mo_data_o), int'(held));
    end
    chk(mo_data_o == exp, req, int'(mo_data_o), int'(exp));
    mo_ready_i = 1'b1;
    @(negedge clk_i);
    mo_ready_i = 1'b0;
  endtask

  task automatic get_request(input int r, input logic [7:0] off, input bit stall);
    get_byte(8'h01, stall, "R2 byte0");
    get_byte(8'h03, 1'b0, "R2 byte1");
    get_byte(8'h01, stall, "R2 byte2");
    get_byte(rung(r), 1'b0, (r == 0) ? "R3 period" : "R4 period");
    get_byte(off, stall, "R3 offset");
    chk(!mo_valid_o, "R2 end", int'(mo_valid_o), 0);
  endtask

  task automatic put_byte(input logic [7:0] b, input bit last);
    mi_data_i  = b;
    mi_valid_i = 1'b1;
    mi_last_i  = last;
    @(negedge clk_i);
    mi_valid_i = 1'b0;
    mi_last_i  = 1'b0;
  endtask

  task automatic start_neg(input logic [7:0] off);
    req_offset_i = off;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    req_offset_i = 8'hAA;
  endtask

  task automatic expect_result(input bit s, input logic [7:0] p, input logic [7:0] o, input string req);
    chk(done_o == 1'b1, "R10 done", int'(done_o), 1);
    chk(sync_mode_o == s, req, int'(sync_mode_o), int'(s));
    chk(period_o == p, req, int'(period_o), int'(p));
    chk(offset_o == o, req, int'(offset_o), int'(o));
    @(negedge clk_i);
    chk(done_o == 1'b0, "R10 pulse", int'(done_o), 0);
    chk(period_o == p && offset_o == o, "R10 hold", int'(period_o), int'(p));
  endtask

  initial begin
    #(200000 * 10ns);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] p, o, ep;
    bit es;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(!done_o && !sync_mode_o && !mo_valid_o, "R1 flags", int'({done_o, sync_mode_o, mo_valid_o}), 0);
    chk(period_o == 0 && offset_o == 0, "R1 result", int'(period_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // sweep rejects, proposal relative to rung, zero/nonzero offset (R4 R6 R7 R8)
    for (int k = 0; k < 5; k++) begin
      for (int pv = 0; pv < 3; pv++) begin
        for (int ov = 0; ov < 2; ov++) begin
          o = (ov == 0) ? 8'd0 : 8'(4 + k + pv);
          p = (pv == 0) ? rung(k) - 8'd1 : (pv == 1) ? rung(k) : rung(k) + 8'd7;
          start_neg(8'h0F);
          for (int r = 0; r <= k; r++) begin
            get_request(r, 8'h0F, r[0]);
            if (r < k) put_byte(8'h07, 1'b1);
          end
          // R11: start during wait must not restart
          start_i = 1'b1;
          @(negedge clk_i);
          start_i = 1'b0;
          chk(!mo_valid_o, "R11 start ignored", int'(mo_valid_o), 0);
          put_byte(8'h01, 1'b0);
          put_byte(8'h03, 1'b0);
          put_byte(8'h01, 1'b0);
          put_byte(p, 1'b0);
          put_byte(o, 1'b1);
          es = (o != 0);
          ep = !es ? 8'd0 : (p < rung(k)) ? rung(k) : p;
          expect_result(es, ep, es ? o : 8'd0,
                        !es ? "R8 zero offset" : (pv == 0) ? "R7 clamp" : "R6 adopt");
        end
      end
    end

    // R5: reject every rung
    start_neg(8'h08);
    for (int r = 0; r < 5; r++) begin
      get_request(r, 8'h08, 1'b0);
      put_byte(8'h07, 1'b1);
    end
    chk(!mo_valid_o, "R5 no resend", int'(mo_valid_o), 0);
    expect_result(1'b0, 8'd0, 8'd0, "R5 exhausted");

    // R11: bytes while idle ignored; set a sync result first
    start_neg(8'h08);
    get_request(0, 8'h08, 1'b0);
    put_byte(8'h01, 1'b0); put_byte(8'h03, 1'b0); put_byte(8'h01, 1'b0);
    put_byte(8'h30, 1'b0); put_byte(8'h06, 1'b1);
    expect_result(1'b1, 8'h30, 8'h06, "R6 accept");
    put_byte(8'h07, 1'b1);
    put_byte(8'h01, 1'b1);
    chk(!done_o && !mo_valid_o, "R11 idle bytes", int'({done_o, mo_valid_o}), 0);
    chk(sync_mode_o && period_o == 8'h30 && offset_o == 8'h06, "R11 result kept", int'(period_o), 8'h30);

    // R9: malformed replies
    for (int v = 0; v < 3; v++) begin
      start_neg(8'h08);
      get_request(0, 8'h08, 1'b0);
      if (v == 0) begin
        put_byte(8'h07, 1'b0); put_byte(8'h00, 1'b1);
      end else if (v == 1) begin
        put_byte(8'h01, 1'b0); put_byte(8'h03, 1'b0); put_byte(8'h03, 1'b0);
        put_byte(8'h30, 1'b0); put_byte(8'h06, 1'b1);
      end else begin
        put_byte(8'h01, 1'b0); put_byte(8'h03, 1'b0); put_byte(8'h01, 1'b0);
        put_byte(8'h30, 1'b0); put_byte(8'h06, 1'b0); put_byte(8'h00, 1'b1);
      end
      expect_result(1'b0, 8'd0, 8'd0, "R9 other reply");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule